// File: doc/BRIEF.md
# Calendar and Time-of-Day Counter

This block holds a complete wall-clock date: year, month, day of month, day of week, hour, minute and second. A one-second tick from an external real-time seconds source steps the seconds. Carries then ripple through minutes, hours, days, months and years. Month lengths follow the usual table. February takes its extra day on a simple four-year cycle.

The year is stored as an offset from 0 to 99. An offset that divides evenly by four is a leap year. There is no century exception.

Internally the hour is always kept in 24-hour form. A mode input selects how the hour output is presented: either as the raw 0–23 value, or as 12, 1 … 11 with a separate afternoon flag. A load strobe writes every field in one cycle so that software or a higher-level controller can set the clock. A one-cycle wrap strobe marks the moment the year offset rolls from 99 back to 0.

Top module: `cal_clock_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the fields read year 0, month 1, day 1, weekday 0, 00:00:00. The wrap strobe reads 0.
- R2: A cycle with `tick_i` high and `load_i` low advances the seconds by one. A cycle with both low leaves every field unchanged.
- R3: Seconds wrap from 59 to 0 and advance the minute. Minutes wrap from 59 to 0 and advance the hour. Hours wrap from 23 to 0 and advance the date.
- R4: Month lengths in days are 31, 28/29, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 for months 1 to 12. Advancing past the last day sets the day to 1 and steps the month.
- R5: February has 29 days when the year offset is divisible by 4, and 28 days otherwise.
- R6: Advancing past December 31 sets month 1, day 1 and steps the year. From year 99 the year wraps to 0, and `wrap_o` is high for exactly the one cycle after that tick.
- R7: The weekday (0–6) steps by one on every date advance and wraps from 6 to 0.
- R8: With `mode12_i` low, `hour_o` equals the stored hour 0–23. With it high, stored hour 0 reads 12, hours 1–12 read unchanged, and hours 13–23 read 1–11. `pm_o` is high exactly when the stored hour is 12 or more, in either mode.
- R9: When `load_i` is high, every field takes its load value in the following cycle, given in 24-hour form and assumed legal. This holds even if `tick_i` is high in the same cycle, and `wrap_o` stays low.
- R10: `mode12_i` changes only the presentation of the hour. Switching it has no effect on any stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second advance pulse |
| load_i | input | 1 | Write all fields from the load inputs |
| load_year_i | input | 7 | Year offset to load (0–99) |
| load_month_i | input | 4 | Month to load (1–12) |
| load_day_i | input | 5 | Day of month to load |
| load_dow_i | input | 3 | Weekday to load (0–6) |
| load_hour_i | input | 5 | Hour to load, 24-hour form |
| load_min_i | input | 6 | Minute to load |
| load_sec_i | input | 6 | Second to load |
| mode12_i | input | 1 | 1 = 12-hour presentation |
| year_o | output | 7 | Year offset |
| month_o | output | 4 | Month 1–12 |
| day_o | output | 5 | Day of month |
| dow_o | output | 3 | Weekday 0–6 |
| hour_o | output | 5 | Hour in the selected form |
| pm_o | output | 1 | Afternoon flag |
| min_o | output | 6 | Minute |
| sec_o | output | 6 | Second |
| wrap_o | output | 1 | One-cycle year wrap strobe |

## Verification
The assertions cover the behaviours that hold cycle by cycle:
- fields holding without a tick;
- the seconds wrap;
- load priority;
- field ranges and the 12-hour output range;
- the date the wrap strobe must coincide with.

The month-length table, the leap rule and the weekday sequence over long runs can only be shown by the bench. It sweeps every month end over several leap cycles and the final year. It then runs more than a full day of ticks and compares against arithmetic expectations. The 12-hour mapping is swept over all 24 stored hours.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int DOW_W  = 3;
    localparam int YEAR_W = 7;

    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HOUR_LAST = 23;
    localparam int HALF_DAY  = 12;
    localparam int DOW_LAST  = 6;

    typedef enum logic [MON_W-1:0] {
        M_JAN = 4'd1, M_FEB = 4'd2, M_MAR = 4'd3, M_APR = 4'd4,
        M_MAY = 4'd5, M_JUN = 4'd6, M_JUL = 4'd7, M_AUG = 4'd8,
        M_SEP = 4'd9, M_OCT = 4'd10, M_NOV = 4'd11, M_DEC = 4'd12
    } month_e;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } tod_t;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DAY_W-1:0]  day;
        logic [DOW_W-1:0]  dow;
    } date_t;

    function automatic logic is_leap(input logic [YEAR_W-1:0] yr, input int period);
        return (int'(yr) % period) == 0;
    endfunction

    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] mon,
                                                   input logic leap);
        case (mon)
            M_FEB:                         return leap ? DAY_W'(29) : DAY_W'(28);
            M_APR, M_JUN, M_SEP, M_NOV:    return DAY_W'(30);
            default:                       return DAY_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/cal_tod_counter.sv
module cal_tod_counter
    import cal_clock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  tod_t load_val,
    output tod_t tod,
    output logic day_step
);

    logic sec_end, min_end, hour_end;

    assign sec_end  = (tod.sec  == SEC_W'(SEC_LAST));
    assign min_end  = (tod.min  == MIN_W'(MIN_LAST));
    assign hour_end = (tod.hour == HOUR_W'(HOUR_LAST));

    // Carry into the date is only meaningful when the tick is not overridden by a load.
    assign day_step = tick && !load && sec_end && min_end && hour_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            tod <= '0;
        end else if (load) begin
            tod <= load_val;
        end else if (tick) begin
            if (!sec_end) begin
                tod.sec <= tod.sec + SEC_W'(1);
            end else begin
                tod.sec <= '0;
                if (!min_end) begin
                    tod.min <= tod.min + MIN_W'(1);
                end else begin
                    tod.min <= '0;
                    tod.hour <= hour_end ? '0 : tod.hour + HOUR_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
    import cal_clock_pkg::*;
#(
    parameter int YEAR_SPAN   = 100,
    parameter int LEAP_PERIOD = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  load,
    input  date_t load_val,
    output date_t date,
    output logic  wrap
);

    localparam logic [YEAR_W-1:0] YEAR_LAST = YEAR_W'(YEAR_SPAN - 1);

    logic leap, last_day, last_month, last_year;

    assign leap       = is_leap(date.year, LEAP_PERIOD);
    assign last_day   = (date.day == month_len(date.month, leap));
    assign last_month = (date.month == M_DEC);
    assign last_year  = (date.year == YEAR_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            date.year  <= '0;
            date.month <= M_JAN;
            date.day   <= DAY_W'(1);
            date.dow   <= '0;
            wrap       <= 1'b0;
        end else if (load) begin
            date <= load_val;
            wrap <= 1'b0;
        end else begin
            wrap <= step && last_day && last_month && last_year;
            if (step) begin
                date.dow <= (date.dow == DOW_W'(DOW_LAST)) ? '0 : date.dow + DOW_W'(1);
                if (!last_day) begin
                    date.day <= date.day + DAY_W'(1);
                end else begin
                    date.day <= DAY_W'(1);
                    if (!last_month) begin
                        date.month <= date.month + MON_W'(1);
                    end else begin
                        date.month <= M_JAN;
                        date.year  <= last_year ? '0 : date.year + YEAR_W'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cal_hour_view.sv
module cal_hour_view
    import cal_clock_pkg::*;
(
    input  logic [HOUR_W-1:0] hour24,
    input  logic              mode12,
    output logic [HOUR_W-1:0] hour_out,
    output logic              pm
);

    localparam logic [HOUR_W-1:0] NOON = HOUR_W'(HALF_DAY);

    always_comb begin
        pm = (hour24 >= NOON);
        if (!mode12) begin
            hour_out = hour24;
        end else if (hour24 == '0) begin
            hour_out = NOON;
        end else if (hour24 > NOON) begin
            hour_out = hour24 - NOON;
        end else begin
            hour_out = hour24;
        end
    end

endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
    import cal_clock_pkg::*;
#(
    parameter int YEAR_SPAN   = 100,
    parameter int LEAP_PERIOD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [YEAR_W-1:0] load_year_i,
    input  logic [MON_W-1:0]  load_month_i,
    input  logic [DAY_W-1:0]  load_day_i,
    input  logic [DOW_W-1:0]  load_dow_i,
    input  logic [HOUR_W-1:0] load_hour_i,
    input  logic [MIN_W-1:0]  load_min_i,
    input  logic [SEC_W-1:0]  load_sec_i,
    input  logic              mode12_i,
    output logic [YEAR_W-1:0] year_o,
    output logic [MON_W-1:0]  month_o,
    output logic [DAY_W-1:0]  day_o,
    output logic [DOW_W-1:0]  dow_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic              pm_o,
    output logic [MIN_W-1:0]  min_o,
    output logic [SEC_W-1:0]  sec_o,
    output logic              wrap_o
);

    tod_t  tod_q, tod_ld;
    date_t date_q, date_ld;
    logic  day_step;

    assign tod_ld  = '{hour: load_hour_i, min: load_min_i, sec: load_sec_i};
    assign date_ld = '{year: load_year_i, month: load_month_i,
                       day: load_day_i, dow: load_dow_i};

    cal_tod_counter u_tod (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_i),
        .load     (load_i),
        .load_val (tod_ld),
        .tod      (tod_q),
        .day_step (day_step)
    );

    cal_date_counter #(
        .YEAR_SPAN   (YEAR_SPAN),
        .LEAP_PERIOD (LEAP_PERIOD)
    ) u_date (
        .clk      (clk),
        .rst      (rst),
        .step     (day_step),
        .load     (load_i),
        .load_val (date_ld),
        .date     (date_q),
        .wrap     (wrap_o)
    );

    cal_hour_view u_view (
        .hour24   (tod_q.hour),
        .mode12   (mode12_i),
        .hour_out (hour_o),
        .pm       (pm_o)
    );

    assign year_o  = date_q.year;
    assign month_o = date_q.month;
    assign day_o   = date_q.day;
    assign dow_o   = date_q.dow;
    assign min_o   = tod_q.min;
    assign sec_o   = tod_q.sec;

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
    import cal_clock_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              load_i,
    input logic [YEAR_W-1:0] load_year_i,
    input logic [SEC_W-1:0]  load_sec_i,
    input logic [HOUR_W-1:0] load_hour_i,
    input logic              mode12_i,
    input logic [YEAR_W-1:0] year_o,
    input logic [MON_W-1:0]  month_o,
    input logic [DAY_W-1:0]  day_o,
    input logic [DOW_W-1:0]  dow_o,
    input logic [HOUR_W-1:0] hour_o,
    input logic [MIN_W-1:0]  min_o,
    input logic [SEC_W-1:0]  sec_o,
    input logic              wrap_o
);

    // R2
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(day_o)
                                  && $stable(month_o) && $stable(year_o) && $stable(dow_o)));

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && sec_o == 6'd59) |=> (sec_o == 6'd0 && !$stable(min_o)));

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (sec_o == $past(load_sec_i) && year_o == $past(load_year_i) && !wrap_o));

    // R6
    wrap_date_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (year_o == 7'd0 && month_o == 4'd1 && day_o == 5'd1
                    && min_o == 6'd0 && sec_o == 6'd0));

    // R8
    hour12_range_chk: assert property (@(posedge clk) disable iff (rst)
        mode12_i |-> (hour_o >= 5'd1 && hour_o <= 5'd12));

    // R7
    dow_range_chk: assert property (@(posedge clk) disable iff (rst)
        dow_o <= 3'd6);

    // R4
    date_range_chk: assert property (@(posedge clk) disable iff (rst)
        (month_o >= 4'd1 && month_o <= 4'd12 && day_o >= 5'd1 && day_o <= 5'd31
         && load_hour_i <= 5'd31));

endmodule

bind cal_clock_top cal_clock_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .load_i      (load_i),
    .load_year_i (load_year_i),
    .load_sec_i  (load_sec_i),
    .load_hour_i (load_hour_i),
    .mode12_i    (mode12_i),
    .year_o      (year_o),
    .month_o     (month_o),
    .day_o       (day_o),
    .dow_o       (dow_o),
    .hour_o      (hour_o),
    .min_o       (min_o),
    .sec_o       (sec_o),
    .wrap_o      (wrap_o)
);

// File: tb/cal_clock_top_tb.sv
module cal_clock_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0, load_i = 1'b0, mode12_i = 1'b0;
    logic [6:0] load_year_i = '0;
    logic [3:0] load_month_i = 4'd1;
    logic [4:0] load_day_i = 5'd1;
    logic [2:0] load_dow_i = '0;
    logic [4:0] load_hour_i = '0;
    logic [5:0] load_min_i = '0, load_sec_i = '0;
    logic [6:0] year_o;
    logic [3:0] month_o;
    logic [4:0] day_o, hour_o;
    logic [2:0] dow_o;
    logic [5:0] min_o, sec_o;
    logic       pm_o, wrap_o;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_clock_top dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        return 30 + ((m + m / 8) % 2);
    endfunction

    task automatic load_all(input int y, input int mo, input int d, input int w,
                            input int h, input int mi, input int s, input bit with_tick);
        @(negedge clk);
        load_year_i = 7'(y); load_month_i = 4'(mo); load_day_i = 5'(d);
        load_dow_i = 3'(w); load_hour_i = 5'(h); load_min_i = 6'(mi); load_sec_i = 6'(s);
        load_i = 1'b1; tick_i = with_tick;
        @(negedge clk);
        load_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic one_tick();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        int ny, nm, ed, em, eh;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        chk("R1 year", year_o, 0); chk("R1 month", month_o, 1); chk("R1 day", day_o, 1);
        chk("R1 dow", dow_o, 0); chk("R1 hour", hour_o, 0); chk("R1 min", min_o, 0);
        chk("R1 sec", sec_o, 0); chk("R1 wrap", wrap_o, 0);

        // R2: idle holds, one tick advances
        repeat (5) @(negedge clk);
        chk("R2 idle sec", sec_o, 0);
        one_tick();
        chk("R2 tick sec", sec_o, 1);

        // R3 / R7: long run, 90060 further ticks -> 1 day 01:01:01
        @(negedge clk); tick_i = 1'b1;
        repeat (90060) @(negedge clk);
        tick_i = 1'b0;
        chk("R3 run sec", sec_o, 1); chk("R3 run min", min_o, 1);
        chk("R3 run hour", hour_o, 1); chk("R3 run day", day_o, 2);
        chk("R7 run dow", dow_o, 1);

        // R4 R5 R6 R7: sweep every month end over years 0..7 and 99
        for (int yi = 0; yi < 9; yi++) begin
            int y;
            y = (yi == 8) ? 99 : yi;
            for (int m = 1; m <= 12; m++) begin
                load_all(y, m, dim(m, y), m % 7, 23, 59, 59, 1'b0);
                one_tick();
                nm = (m == 12) ? 1 : m + 1;
                ny = (m == 12) ? ((y == 99) ? 0 : y + 1) : y;
                chk("R4 day", day_o, 1); chk("R4 month", month_o, nm);
                chk("R6 year", year_o, ny);
                chk("R7 dow", dow_o, (m % 7 == 6) ? 0 : m % 7 + 1);
                chk("R3 hour", hour_o, 0);
                chk("R6 wrap", wrap_o, (y == 99 && m == 12) ? 1 : 0);
                @(negedge clk);
                chk("R6 wrap one cycle", wrap_o, 0);
            end
            // R5: Feb 28 advances to 29 only in leap years
            load_all(y, 2, 28, 0, 23, 59, 59, 1'b0);
            one_tick();
            ed = (y % 4 == 0) ? 29 : 1; em = (y % 4 == 0) ? 2 : 3;
            chk("R5 feb day", day_o, ed); chk("R5 feb month", month_o, em);
        end

        // R8: 12/24-hour presentation over all stored hours
        for (int h = 0; h < 24; h++) begin
            load_all(10, 6, 15, 2, h, 0, 0, 1'b0);
            mode12_i = 1'b0; #1;
            chk("R8 hour24", hour_o, h); chk("R8 pm24", pm_o, (h >= 12) ? 1 : 0);
            mode12_i = 1'b1; #1;
            eh = (h % 12 == 0) ? 12 : h % 12;
            chk("R8 hour12", hour_o, eh); chk("R8 pm12", pm_o, (h >= 12) ? 1 : 0);
            mode12_i = 1'b0;
        end
        // R8: 11:59:59 -> 12 PM
        load_all(10, 6, 15, 2, 11, 59, 59, 1'b0);
        mode12_i = 1'b1;
        one_tick();
        chk("R8 noon hour", hour_o, 12); chk("R8 noon pm", pm_o, 1);
        mode12_i = 1'b0;

        // R9: load beats a same-cycle tick
        load_all(42, 9, 30, 5, 23, 59, 59, 1'b1);
        chk("R9 sec", sec_o, 59); chk("R9 day", day_o, 30); chk("R9 month", month_o, 9);
        chk("R9 year", year_o, 42); chk("R9 hour", hour_o, 23); chk("R9 wrap", wrap_o, 0);

        // R10: mode toggling leaves stored fields alone
        load_all(7, 3, 4, 1, 15, 30, 45, 1'b0);
        @(negedge clk); mode12_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 hour12", hour_o, 3);
        mode12_i = 1'b0;
        @(negedge clk);
        chk("R10 hour", hour_o, 15); chk("R10 min", min_o, 30); chk("R10 sec", sec_o, 45);
        chk("R10 day", day_o, 4);

        finish_run();
    end

endmodule